// File: doc/BRIEF.md
# E1 Timeslot Capture and Insert Ring Buffer

This block sits beside the serial datapath of a 2.048 Mbit/s E1 framer. It runs on the bit clock, one clock per line bit. A frame is 256 bits long, with 32 timeslots of 8 bits each, sent most significant bit first. A frame-sync pulse marks the first bit of timeslot 0.

Once per frame the block collects the octet of one host-chosen receive timeslot into a 16-entry receive ring. In the same frame it replaces the octet of one host-chosen transmit timeslot with the next byte of a 16-entry transmit ring. The transmit ring is replayed cyclically.

Software reaches the block through a small register port. Through it, software loads the transmit ring, drains the receive ring, reads the pointers and the fill status, and picks the two slots. The serial side is a fixed-rate stream with no back-pressure. The block can never stall the line. When the receive ring is full, each new capture overwrites the oldest unread byte.

Top module: `e1_ts_ring`

## Requirements
- R1: Frame position rules. The cycle with `fsync` high is bit position 0 (line bit 1) of slot 0. The block then counts 8 cycles per slot and 32 slots per frame, wrapping to slot 0 after 256 cycles even when no `fsync` arrives. An `fsync` at any point restarts the count.
- R2: Receive capture. When the capture enable (CTRL bit 1) is set, the 8 `rx_bit` values of the active receive slot form one byte, first bit in the MSB. After the eighth bit the byte is stored at the receive write pointer, and that pointer steps by one, from 15 back to 0.
- R3: `rx_wrap_irq` is high for exactly one cycle: the cycle that follows a capture that moved the receive write pointer from 15 to 0.
- R4: Transmit insertion. While the insert enable (CTRL bit 0) is set, `tx_out_bit` in the 8 cycles of the active transmit slot carries the transmit-ring byte at the read pointer, MSB first. In all other slots it equals `tx_in_bit`. The read pointer steps after the eighth bit and wraps from 15 to 0, so the ring replays.
- R5: While the insert enable is clear, `tx_out_bit` equals `tx_in_bit` in every slot and the transmit read pointer does not move.
- R6: Slot numbers written to RXSEL (address 1) or TXSEL (address 2) take effect at the next frame start (slot 0, bit 0), never inside a frame. Reading either address returns the last value written.
- R7: Reading RXDATA (address 4) returns the oldest unread byte and removes it. On an empty ring the read returns 0 and removes nothing. STAT (address 6) reads as {0, full in bit 6, empty in bit 5, unread count in bits 4:0}.
- R8: When the receive ring holds 16 unread bytes, a capture overwrites the oldest byte. The count stays at 16.
- R9: While `ctl_stream_mode` is high, every host read returns 0 and every host write is ignored. This includes ring pushes and pops.
- R10: PTR (address 5) reads {receive write pointer in bits 7:4, transmit read pointer in bits 3:0}. HPTR (address 7) reads {receive host read pointer in bits 7:4, transmit host write pointer in bits 3:0}. Each write to TXDATA (address 3) stores a byte at the host write pointer and steps that pointer.
- R11: After reset, CTRL, RXSEL, TXSEL and all pointers are 0, STAT reads 8'h20, `rx_wrap_irq` is low and `tx_out_bit` follows `tx_in_bit`.
- R12: `host_rdata` holds, in the cycle after a clock edge with `host_rd` high, the value of the register addressed at that edge. At other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Marks bit 0 of slot 0 |
| rx_bit | input | 1 | Receive serial data |
| tx_in_bit | input | 1 | Transmit through-data |
| tx_out_bit | output | 1 | Transmit data after insertion |
| rx_wrap_irq | output | 1 | One-cycle pulse on a receive write-pointer wrap |
| ctl_stream_mode | input | 1 | Host control over TDM stream; ring access blocked |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, one cycle after the strobe |

## Verification
The serial stream uses byte values that depend on both frame and slot. This lets each compared bit tell a right-slot, right-byte insertion apart from a neighbouring slot or a stale ring entry. The frame pattern is varied in three ways: frames aligned by `fsync`, frames left to run free with no `fsync`, and a truncated frame followed by a fresh `fsync`. Together these separate counter wrap from resynchronisation. A slot change written in the middle of a frame, ahead of the newly chosen slot, shows whether the change is correctly held back to the frame boundary. Filling the receive ring past 16 entries without reading, then draining it to empty, exercises overwrite, pointer wrap, the interrupt pulse and the zero read on an empty ring.

// File: rtl/e1_ts_pkg.sv
package e1_ts_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_RXSEL = 3'd1,
    REG_TXSEL = 3'd2,
    REG_TXWR  = 3'd3,
    REG_RXRD  = 3'd4,
    REG_PTR   = 3'd5,
    REG_STAT  = 3'd6,
    REG_HPTR  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/e1_ts_timing.sv
module e1_ts_timing #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  output logic [BIT_W-1:0]  cur_bit,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              frame_start
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WIDTH - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;

  assign cur_bit     = fsync ? '0 : bit_q;
  assign cur_slot    = fsync ? '0 : slot_q;
  assign frame_start = (cur_bit == '0) && (cur_slot == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (cur_bit == BIT_LAST) begin
      bit_q  <= '0;
      slot_q <= (cur_slot == SLOT_LAST) ? '0 : cur_slot + 1'b1;
    end else begin
      bit_q  <= cur_bit + 1'b1;
      slot_q <= cur_slot;
    end
  end

  // R1
  fsync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (bit_q == BIT_W'(1) && slot_q == '0));
endmodule

// File: rtl/e1_ts_rx_ring.sv
module e1_ts_rx_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SLOTS = 32,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BIT_W-1:0]  cur_bit,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              frame_start,
  input  logic [SLOT_W-1:0] sel_pend,
  input  logic              cap_en,
  input  logic              rx_bit,
  input  logic              pop,
  output logic [WIDTH-1:0]  pop_data,
  output logic [LVL_W-1:0]  level,
  output logic [PTR_W-1:0]  wp,
  output logic [PTR_W-1:0]  hrp,
  output logic              wrap_irq
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIDTH - 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [SLOT_W-1:0] act_q, eff_slot;
  logic [WIDTH-1:0]  sh_q, byte_now;
  logic [WIDTH-1:0]  mem [DEPTH];
  logic              in_slot, push, pop_ok, full, empty;

  assign eff_slot = frame_start ? sel_pend : act_q;
  assign in_slot  = (cur_slot == eff_slot);
  assign byte_now = {sh_q[WIDTH-2:0], rx_bit};
  assign push     = cap_en && in_slot && (cur_bit == BIT_LAST);
  assign full     = (level == LVL_FULL);
  assign empty    = (level == '0);
  assign pop_ok   = pop && !empty;
  assign pop_data = empty ? '0 : mem[hrp];

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= eff_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sh_q <= '0;
    else if (in_slot) sh_q <= byte_now;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= byte_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      wrap_irq <= 1'b0;
    end else begin
      wrap_irq <= push && (wp == PTR_LAST);
      if (push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hrp   <= '0;
      level <= '0;
    end else begin
      if (pop_ok || (push && full))
        hrp <= (hrp == PTR_LAST) ? '0 : hrp + 1'b1;
      case ({push, pop_ok})
        2'b10:   if (!full) level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_FULL);

  // R3
  wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> (wp == '0 && $past(wp) == PTR_LAST));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> ($stable(hrp) && level == '0));
endmodule

// File: rtl/e1_ts_tx_ring.sv
module e1_ts_tx_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SLOTS = 32,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BIT_W-1:0]  cur_bit,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              frame_start,
  input  logic [SLOT_W-1:0] sel_pend,
  input  logic              ins_en,
  input  logic              tx_in_bit,
  input  logic              wr,
  input  logic [WIDTH-1:0]  wdata,
  output logic              tx_out_bit,
  output logic [PTR_W-1:0]  rp,
  output logic [PTR_W-1:0]  hwp
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIDTH - 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [SLOT_W-1:0] act_q, eff_slot;
  logic [WIDTH-1:0]  mem [DEPTH];
  logic [BIT_W-1:0]  bit_idx;
  logic              ins;

  assign eff_slot   = frame_start ? sel_pend : act_q;
  assign ins        = ins_en && (cur_slot == eff_slot);
  assign bit_idx    = BIT_LAST - cur_bit;
  assign tx_out_bit = ins ? mem[rp][bit_idx] : tx_in_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= eff_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      hwp <= '0;
    end else if (wr) begin
      mem[hwp] <= wdata;
      hwp      <= (hwp == PTR_LAST) ? '0 : hwp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rp <= '0;
    else if (ins && cur_bit == BIT_LAST)
      rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
  end

  // R5
  idle_rp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_en |=> $stable(rp));

  // R4
  rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rp != $past(rp)) |-> $past(ins_en && cur_bit == BIT_LAST));
endmodule

// File: rtl/e1_ts_host.sv
module e1_ts_host
  import e1_ts_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SLOTS = 32,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_stream_mode,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WIDTH-1:0]  host_wdata,
  output logic [WIDTH-1:0]  host_rdata,
  input  logic [PTR_W-1:0]  rx_wp,
  input  logic [PTR_W-1:0]  rx_hrp,
  input  logic [PTR_W-1:0]  tx_rp,
  input  logic [PTR_W-1:0]  tx_hwp,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [WIDTH-1:0]  rx_pop_data,
  output logic              ins_en,
  output logic              cap_en,
  output logic [SLOT_W-1:0] rx_sel,
  output logic [SLOT_W-1:0] tx_sel,
  output logic              tx_wr,
  output logic              rx_pop
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic       acc_wr, acc_rd, rx_full, rx_empty;
  logic [WIDTH-1:0] rd_val;
  reg_addr_e  addr;

  assign addr     = reg_addr_e'(host_addr);
  assign acc_wr   = host_wr && !ctl_stream_mode;
  assign acc_rd   = host_rd && !ctl_stream_mode;
  assign tx_wr    = acc_wr && (addr == REG_TXWR);
  assign rx_pop   = acc_rd && (addr == REG_RXRD);
  assign rx_full  = (rx_level == LVL_FULL);
  assign rx_empty = (rx_level == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_en <= 1'b0;
      cap_en <= 1'b0;
      rx_sel <= '0;
      tx_sel <= '0;
    end else if (acc_wr) begin
      case (addr)
        REG_CTRL: begin
          ins_en <= host_wdata[0];
          cap_en <= host_wdata[1];
        end
        REG_RXSEL: rx_sel <= host_wdata[SLOT_W-1:0];
        REG_TXSEL: tx_sel <= host_wdata[SLOT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      REG_CTRL:  rd_val = WIDTH'({cap_en, ins_en});
      REG_RXSEL: rd_val = WIDTH'(rx_sel);
      REG_TXSEL: rd_val = WIDTH'(tx_sel);
      REG_RXRD:  rd_val = rx_pop_data;
      REG_PTR:   rd_val = WIDTH'({rx_wp, tx_rp});
      REG_STAT:  rd_val = WIDTH'({rx_full, rx_empty, rx_level});
      REG_HPTR:  rd_val = WIDTH'({rx_hrp, tx_hwp});
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= acc_rd ? rd_val : '0;
  end

  // R9
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stream_mode && host_rd) |=> (host_rdata == '0));

  // R9
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stream_mode && host_wr) |=> ($stable(ins_en) && $stable(cap_en) &&
                                       $stable(rx_sel) && $stable(tx_sel) &&
                                       $stable(tx_hwp)));

  // R12
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> (host_rdata == '0));
endmodule

// File: rtl/e1_ts_ring.sv
module e1_ts_ring
  import e1_ts_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SLOTS = 32,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              rx_bit,
  input  logic              tx_in_bit,
  output logic              tx_out_bit,
  output logic              rx_wrap_irq,
  input  logic              ctl_stream_mode,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WIDTH-1:0]  host_wdata,
  output logic [WIDTH-1:0]  host_rdata
);
  logic [BIT_W-1:0]  cur_bit;
  logic [SLOT_W-1:0] cur_slot, rx_sel, tx_sel;
  logic              frame_start, ins_en, cap_en, tx_wr, rx_pop;
  logic [PTR_W-1:0]  rx_wp, rx_hrp, tx_rp, tx_hwp;
  logic [LVL_W-1:0]  rx_level;
  logic [WIDTH-1:0]  rx_pop_data;

  e1_ts_timing #(.SLOTS(SLOTS), .WIDTH(WIDTH)) u_timing (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .cur_bit(cur_bit), .cur_slot(cur_slot), .frame_start(frame_start)
  );

  e1_ts_rx_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SLOTS(SLOTS)) u_rx (
    .clk(clk), .rst_n(rst_n), .cur_bit(cur_bit), .cur_slot(cur_slot),
    .frame_start(frame_start), .sel_pend(rx_sel), .cap_en(cap_en),
    .rx_bit(rx_bit), .pop(rx_pop), .pop_data(rx_pop_data),
    .level(rx_level), .wp(rx_wp), .hrp(rx_hrp), .wrap_irq(rx_wrap_irq)
  );

  e1_ts_tx_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SLOTS(SLOTS)) u_tx (
    .clk(clk), .rst_n(rst_n), .cur_bit(cur_bit), .cur_slot(cur_slot),
    .frame_start(frame_start), .sel_pend(tx_sel), .ins_en(ins_en),
    .tx_in_bit(tx_in_bit), .wr(tx_wr), .wdata(host_wdata),
    .tx_out_bit(tx_out_bit), .rp(tx_rp), .hwp(tx_hwp)
  );

  e1_ts_host #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SLOTS(SLOTS)) u_host (
    .clk(clk), .rst_n(rst_n), .ctl_stream_mode(ctl_stream_mode),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_wp(rx_wp), .rx_hrp(rx_hrp), .tx_rp(tx_rp), .tx_hwp(tx_hwp),
    .rx_level(rx_level), .rx_pop_data(rx_pop_data),
    .ins_en(ins_en), .cap_en(cap_en), .rx_sel(rx_sel), .tx_sel(tx_sel),
    .tx_wr(tx_wr), .rx_pop(rx_pop)
  );

  // R6
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && $changed(tx_sel) && ins_en && cur_slot == tx_sel &&
     $past(cur_slot) != tx_sel) |-> (tx_out_bit == tx_in_bit));
endmodule

// File: tb/sim_e1_ts_ring.sv
module sim_e1_ts_ring;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, rx_bit = 1'b0, tx_in_bit = 1'b0;
  logic ctl_stream_mode = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       tx_out_bit, rx_wrap_irq;
  logic [7:0] host_rdata;

  always #(CLK_P/2) clk = ~clk;

  e1_ts_ring u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_bit(rx_bit),
    .tx_in_bit(tx_in_bit), .tx_out_bit(tx_out_bit), .rx_wrap_irq(rx_wrap_irq),
    .ctl_stream_mode(ctl_stream_mode), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_tx [16];
  int m_tx_rp = 0, m_tx_hwp = 0, m_rx_wp = 0, m_rx_hrp = 0;
  logic [7:0] rx_q [$];
  bit b_tx_en = 0, b_rx_en = 0;
  int pend_tx = 0, pend_rx = 0, act_tx = 0, act_rx = 0;
  int cur_slot = -1, frame_no = 0, next_len = 256;
  bit use_fsync = 1, drv_on = 0;

  typedef struct { bit tx; bit irq; bit ins; } exp_t;
  exp_t exp_q [$];
  exp_t mon_e;

  function automatic logic [7:0] rx_pat(int f, int s);
    return 8'(f * 7 + s * 13 + 1);
  endfunction
  function automatic logic [7:0] tx_pat(int f, int s);
    return 8'(f * 3 + s * 5) ^ 8'hA5;
  endfunction

  task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  // driver: serial stream plus expected-bit scoreboard entries
  initial begin : driver
    int len, s, b;
    bit fs, irq_next;
    logic [7:0] rv, tv;
    exp_t e;
    irq_next = 0;
    for (int k = 0; k < 16; k++) m_tx[k] = '0;
    wait (drv_on);
    forever begin
      len = next_len; fs = use_fsync; next_len = 256;
      act_tx = pend_tx; act_rx = pend_rx;
      for (int i = 0; i < len; i++) begin
        s = i / 8; b = i % 8;
        rv = rx_pat(frame_no, s); tv = tx_pat(frame_no, s);
        @(posedge clk); #1;
        cur_slot = s;
        fsync = fs && (i == 0);
        rx_bit = rv[7-b]; tx_in_bit = tv[7-b];
        e.irq = irq_next; irq_next = 0;
        e.ins = b_tx_en && (s == act_tx);
        e.tx  = e.ins ? m_tx[m_tx_rp][7-b] : tv[7-b];
        if (e.ins && b == 7) m_tx_rp = (m_tx_rp + 1) % 16;
        if (b_rx_en && s == act_rx && b == 7) begin
          if (rx_q.size() == 16) begin
            void'(rx_q.pop_front());
            m_rx_hrp = (m_rx_hrp + 1) % 16;
          end
          rx_q.push_back(rv);
          if (m_rx_wp == 15) irq_next = 1;
          m_rx_wp = (m_rx_wp + 1) % 16;
        end
        exp_q.push_back(e);
      end
      frame_no++;
    end
  end

  // monitor: pops expected bits and compares away from the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      checks++;
      if (tx_out_bit !== mon_e.tx) begin
        fails++;
        $display("FAIL %s tx_out got %0b expected %0b", mon_e.ins ? "R4" : (b_tx_en ? "R6" : "R5"),
                 tx_out_bit, mon_e.tx);
      end
      checks++;
      if (rx_wrap_irq !== mon_e.irq) begin
        fails++;
        $display("FAIL R3 rx_wrap_irq got %0b expected %0b", rx_wrap_irq, mon_e.irq);
      end
    end
  end

  task automatic wait_window();
    do @(posedge clk); while (!(cur_slot == 10 || cur_slot == 11));
  endtask

  task automatic host_write(logic [2:0] a, logic [7:0] d);
    wait_window();
    #1 host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk);
    if (!ctl_stream_mode) begin
      case (a)
        3'd0: begin b_tx_en = d[0]; b_rx_en = d[1]; end
        3'd1: pend_rx = d[4:0];
        3'd2: pend_tx = d[4:0];
        3'd3: begin m_tx[m_tx_hwp] = d; m_tx_hwp = (m_tx_hwp + 1) % 16; end
        default: ;
      endcase
    end
    #1 host_wr = 1'b0;
  endtask

  task automatic host_read(logic [2:0] a, output logic [7:0] d);
    wait_window();
    #1 host_addr = a; host_rd = 1'b1;
    @(posedge clk);
    #1 host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic [7:0] stat_exp();
    int n = rx_q.size();
    return {1'b0, n == 16, n == 0, 5'(n)};
  endfunction

  task automatic pop_check(string tag);
    logic [7:0] got, exp;
    host_read(3'd4, got);
    if (rx_q.size() > 0) begin
      exp = rx_q.pop_front();
      m_rx_hrp = (m_rx_hrp + 1) % 16;
    end else exp = 8'h00;
    check8(tag, got, exp);
  endtask

  task automatic wait_frames(int n);
    int w = frame_no;
    wait (frame_no >= w + n);
  endtask

  initial begin : main
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1; drv_on = 1;
    // R11 reset state
    host_read(3'd0, v); check8("R11 CTRL", v, 8'h00);
    host_read(3'd6, v); check8("R11 STAT", v, 8'h20);
    host_read(3'd5, v); check8("R11 PTR", v, 8'h00);
    // R10 load transmit ring
    for (int i = 0; i < 16; i++) host_write(3'd3, 8'(8'h3C + i * 17));
    host_read(3'd7, v); check8("R10 HPTR", v, 8'h00);
    host_write(3'd2, 8'd5); host_write(3'd1, 8'd3); host_write(3'd0, 8'h03);
    host_read(3'd2, v); check8("R6 TXSEL readback", v, 8'd5);
    wait_frames(3);
    // R6 slot change mid-frame, ahead of new slot 25
    host_write(3'd2, 8'd25);
    wait_frames(2);
    // R2 capture data
    for (int i = 0; i < 4; i++) pop_check("R2 RXDATA");
    host_read(3'd6, v); check8("R7 STAT", v, stat_exp());
    host_read(3'd5, v); check8("R10 PTR", v, 8'((m_rx_wp << 4) | m_tx_rp));
    // R8 overflow
    wait_frames(20);
    host_read(3'd6, v); check8("R8 STAT full", v, stat_exp());
    host_read(3'd7, v); check8("R10 HPTR", v, 8'((m_rx_hrp << 4) | m_tx_hwp));
    host_write(3'd0, 8'h01);
    for (int i = 0; i < 17; i++) pop_check("R7 RXDATA drain");
    host_read(3'd6, v); check8("R7 STAT empty", v, stat_exp());
    // R9 blocked host access
    wait_window(); #1 ctl_stream_mode = 1'b1;
    host_write(3'd2, 8'd9);
    host_write(3'd3, 8'hEE);
    host_read(3'd2, v); check8("R9 read blocked", v, 8'h00);
    host_read(3'd6, v); check8("R9 read blocked", v, 8'h00);
    wait_window(); #1 ctl_stream_mode = 1'b0;
    host_read(3'd2, v); check8("R9 write ignored", v, 8'd25);
    host_read(3'd7, v); check8("R9 HPTR unchanged", v, 8'((m_rx_hrp << 4) | m_tx_hwp));
    // R5 insertion off
    host_write(3'd0, 8'h02);
    wait_frames(2);
    host_read(3'd5, v); check8("R5 PTR", v, 8'((m_rx_wp << 4) | m_tx_rp));
    // R1 free-running frames, then a short frame and resync
    host_write(3'd0, 8'h03);
    use_fsync = 0;
    wait_frames(2);
    use_fsync = 1;
    next_len = 100;
    wait_frames(3);
    host_read(3'd5, v); check8("R1 PTR", v, 8'((m_rx_wp << 4) | m_tx_rp));
    host_read(3'd6, v); check8("R1 STAT", v, stat_exp());
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule